// File: doc/BRIEF.md
# Switchback Clock-Divide Controller

This block sets the system clock divide ratio of a small microcontroller. Software programs a two-bit divide code, a power-management enable, a switchback enable and a stop request through a single register write strobe. Outside power management the code picks /1, /2, /4 or /8. With power management on, code 00 becomes /256 and code 11 selects the slow (32 kHz class) source, which this block models as a long divide of 2^SLOW_LOG2.

When switchback is armed and power management is active, any wake condition from the interrupt, serial, SPI, real-time-clock or debug logic clears the power-management enable in hardware. The divide code is left alone, so a wake from /256 drops to /1 and a wake from the slow source drops to /8. A free-running prescaler turns the effective ratio into a one-cycle clock-enable strobe for the rest of the chip. There is no data stream here: every pin is a plain control or status level.

Top module: `clksw_ctrl`

## Requirements
- R1: With pm_en = 0 the effective divide is 2^div_code: code 00 gives eff_log2 = 0, 01 gives 1, 10 gives 2, 11 gives 3, and slow_src = 0.
- R2: With pm_en = 1, code 00 gives eff_log2 = 8 (/256), code 11 gives eff_log2 = SLOW_LOG2 with slow_src = 1, and codes 01 and 10 keep /2 and /4.
- R3: A cycle with wr_en = 1 loads div_code, pm_en, swb_en and stop_req from the wr_* inputs at that clock edge; the new values are visible on the outputs after that edge.
- R4: If swb_en = 1, pm_en = 1 and a wake condition is true at a clock edge, pm_en is 0 after that edge while div_code keeps its value, so the result is /1 from code 00 and /8 from code 11.
- R5: A wake condition is any of: ext_irq_edge = 1; for a serial port i, ser_rx_en[i] = 1 with ser_rx_pin[i] = 0; ser_tx_en[i] = 1 with ser_tx_wr[i] = 1; spi_slave_mode = 1 with spi_ss_n = 0; spi_tx_en = 1 with spi_tx_wr = 1; rtc_tod_irq = 1; dbg_entry = 1. A raw signal whose enable is 0 is not a wake condition.
- R6: While pm_en = 1 and a wake condition is true, a write with wr_swb_en = 1 leaves swb_en at 0 when it was 0.
- R7: A switchback clear takes priority over a same-cycle write of wr_pm_en = 1: pm_en is 0 after that edge.
- R8: stop_req follows the written stop bit and has no effect on eff_log2 or slow_src.
- R9: clk_en pulses for one cycle once every 2^eff_log2 cycles while eff_log2 is steady (every cycle at eff_log2 = 0).
- R10: With swb_en = 0, or with pm_en = 0, wake conditions leave pm_en unchanged.
- R11: After reset div_code = 00, pm_en = 0, swb_en = 0, stop_req = 0, eff_log2 = 0, and clk_en is 1 every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_div | input | 2 | Divide code to write |
| wr_pm_en | input | 1 | Power-management enable to write |
| wr_swb_en | input | 1 | Switchback enable to write |
| wr_stop | input | 1 | Stop request to write |
| ext_irq_edge | input | 1 | Edge-detected external interrupt |
| ser_rx_en | input | NUM_SER | Serial receiver enables |
| ser_rx_pin | input | NUM_SER | Serial receive pin levels |
| ser_tx_en | input | NUM_SER | Serial transmitter enables |
| ser_tx_wr | input | NUM_SER | Serial transmit buffer write pulses |
| spi_slave_mode | input | 1 | SPI enabled as slave |
| spi_ss_n | input | 1 | SPI slave select, active low |
| spi_tx_en | input | 1 | SPI transmitter enabled |
| spi_tx_wr | input | 1 | SPI transmit buffer write pulse |
| rtc_tod_irq | input | 1 | Time-of-day interrupt |
| dbg_entry | input | 1 | Debug mode entry |
| div_code | output | 2 | Stored divide code |
| pm_en | output | 1 | Power-management enable |
| swb_en | output | 1 | Switchback enable |
| stop_req | output | 1 | Stop mode request |
| eff_log2 | output | EW | log2 of effective divide ratio |
| slow_src | output | 1 | Slow source selected |
| clk_en | output | 1 | Divided clock-enable strobe |

## Verification
Register writes and switchback clears both land at the single clock edge that samples them, so every register output and eff_log2 is due one edge after the stimulus; the bench drives on the falling edge and reads on the next falling edge. The strobe period is measured only after eff_log2 has settled, by counting falling edges between two consecutive strobes and comparing against 2^eff_log2 computed in the bench. The sweep covers all eight code/enable combinations and all nine wake sources from both low-power codes.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef logic [1:0] div_code_t;
  localparam div_code_t CODE_FAST = 2'b00;  // /1, or /256 under power management
  localparam div_code_t CODE_SLOW = 2'b11;  // /8, or slow source under power management
  localparam int unsigned PM_DEEP_LOG2 = 8;

  typedef struct packed {
    div_code_t div;
    logic      pm;
    logic      swb;
    logic      stop;
  } ctrl_t;
endpackage

// File: rtl/clksw_wake.sv
module clksw_wake #(
  parameter int unsigned NUM_SER = 2
) (
  input  logic               ext_irq_edge,
  input  logic [NUM_SER-1:0] ser_rx_en,
  input  logic [NUM_SER-1:0] ser_rx_pin,
  input  logic [NUM_SER-1:0] ser_tx_en,
  input  logic [NUM_SER-1:0] ser_tx_wr,
  input  logic               spi_slave_mode,
  input  logic               spi_ss_n,
  input  logic               spi_tx_en,
  input  logic               spi_tx_wr,
  input  logic               rtc_tod_irq,
  input  logic               dbg_entry,
  output logic               wake
);
  logic [NUM_SER-1:0] ser_hit;

  // R5: each serial port contributes a gated receive and transmit condition
  for (genvar i = 0; i < NUM_SER; i++) begin : g_ser
    assign ser_hit[i] = (ser_rx_en[i] & ~ser_rx_pin[i]) | (ser_tx_en[i] & ser_tx_wr[i]);
  end

  assign wake = ext_irq_edge | (|ser_hit)
              | (spi_slave_mode & ~spi_ss_n) | (spi_tx_en & spi_tx_wr)
              | rtc_tod_irq | dbg_entry;
endmodule

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  wake,
  output ctrl_t ctrl
);
  ctrl_t ctrl_d;
  logic  swb_fire;

  assign swb_fire = ctrl.swb & ctrl.pm & wake;

  always_comb begin
    ctrl_d = ctrl;
    if (wr_en) begin
      ctrl_d = wr_val;
      // R6: arming is refused while in power management with a wake pending
      if (wr_val.swb && !ctrl.swb && ctrl.pm && wake) ctrl_d.swb = 1'b0;
    end
    // R4 / R7: hardware clear wins over software
    if (swb_fire) ctrl_d.pm = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= ctrl_d;
  end

  a_r4_pm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.swb && ctrl.pm && wake) |=> !ctrl.pm);

  a_r4_div_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.swb && ctrl.pm && wake && !wr_en) |=> (ctrl.div == $past(ctrl.div)));

  a_r6_arm_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pm && wake && !ctrl.swb) |=> !ctrl.swb);

  a_r10_no_wake_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.swb && ctrl.pm && !wr_en) |=> ctrl.pm);
endmodule

// File: rtl/clksw_ratio.sv
module clksw_ratio
  import clksw_pkg::*;
#(
  parameter int unsigned SLOW_LOG2 = 9,
  parameter int unsigned EW = 4
) (
  input  div_code_t     div,
  input  logic          pm,
  output logic [EW-1:0] eff_log2,
  output logic          slow_src
);
  always_comb begin
    eff_log2 = EW'(div);                       // R1
    slow_src = 1'b0;
    if (pm) begin                              // R2
      if (div == CODE_FAST) eff_log2 = EW'(PM_DEEP_LOG2);
      else if (div == CODE_SLOW) begin
        eff_log2 = EW'(SLOW_LOG2);
        slow_src = 1'b1;
      end
    end
  end
endmodule

// File: rtl/clksw_prescaler.sv
module clksw_prescaler #(
  parameter int unsigned CW = 9,
  parameter int unsigned EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] eff_log2,
  output logic          clk_en
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // R9: low eff_log2 bits all ones -> one strobe per 2^eff_log2 cycles
  assign mask   = ~({CW{1'b1}} << eff_log2);
  assign clk_en = ((cnt & mask) == mask);

  a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && eff_log2 != '0) |=> (!clk_en || eff_log2 != $past(eff_log2)));

  a_r9_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_log2 == '0) |-> clk_en);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int unsigned NUM_SER   = 2,
  parameter int unsigned SLOW_LOG2 = 9,
  localparam int unsigned CW = (SLOW_LOG2 > PM_DEEP_LOG2) ? SLOW_LOG2 : PM_DEEP_LOG2,
  localparam int unsigned EW = $clog2(CW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_div,
  input  logic               wr_pm_en,
  input  logic               wr_swb_en,
  input  logic               wr_stop,
  input  logic               ext_irq_edge,
  input  logic [NUM_SER-1:0] ser_rx_en,
  input  logic [NUM_SER-1:0] ser_rx_pin,
  input  logic [NUM_SER-1:0] ser_tx_en,
  input  logic [NUM_SER-1:0] ser_tx_wr,
  input  logic               spi_slave_mode,
  input  logic               spi_ss_n,
  input  logic               spi_tx_en,
  input  logic               spi_tx_wr,
  input  logic               rtc_tod_irq,
  input  logic               dbg_entry,
  output logic [1:0]         div_code,
  output logic               pm_en,
  output logic               swb_en,
  output logic               stop_req,
  output logic [EW-1:0]      eff_log2,
  output logic               slow_src,
  output logic               clk_en
);
  ctrl_t wr_val;
  ctrl_t ctrl;
  logic  wake;

  assign wr_val = '{div: wr_div, pm: wr_pm_en, swb: wr_swb_en, stop: wr_stop};

  clksw_wake #(.NUM_SER(NUM_SER)) u_wake (
    .ext_irq_edge(ext_irq_edge), .ser_rx_en(ser_rx_en), .ser_rx_pin(ser_rx_pin),
    .ser_tx_en(ser_tx_en), .ser_tx_wr(ser_tx_wr), .spi_slave_mode(spi_slave_mode),
    .spi_ss_n(spi_ss_n), .spi_tx_en(spi_tx_en), .spi_tx_wr(spi_tx_wr),
    .rtc_tod_irq(rtc_tod_irq), .dbg_entry(dbg_entry), .wake(wake));

  clksw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val), .wake(wake), .ctrl(ctrl));

  clksw_ratio #(.SLOW_LOG2(SLOW_LOG2), .EW(EW)) u_ratio (
    .div(ctrl.div), .pm(ctrl.pm), .eff_log2(eff_log2), .slow_src(slow_src));

  clksw_prescaler #(.CW(CW), .EW(EW)) u_presc (
    .clk(clk), .rst_n(rst_n), .eff_log2(eff_log2), .clk_en(clk_en));

  assign div_code = ctrl.div;
  assign pm_en    = ctrl.pm;
  assign swb_en   = ctrl.swb;
  assign stop_req = ctrl.stop;

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_en && pm_en && wake && wr_en && wr_pm_en) |=> !pm_en);

  a_r8_stop_neutral: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_div == div_code && wr_pm_en == pm_en && !(swb_en && pm_en && wake))
      |=> $stable(eff_log2));
endmodule

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb;
  localparam int SLOW = 9;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_pm_en = 0, wr_swb_en = 0, wr_stop = 0;
  logic [1:0] wr_div = 0;
  logic ext_irq_edge = 0, spi_slave_mode = 0, spi_ss_n = 1, spi_tx_en = 0, spi_tx_wr = 0;
  logic rtc_tod_irq = 0, dbg_entry = 0;
  logic [1:0] ser_rx_en = 0, ser_rx_pin = 2'b11, ser_tx_en = 0, ser_tx_wr = 0;
  logic [1:0] div_code;
  logic pm_en, swb_en, stop_req, slow_src, clk_en;
  logic [3:0] eff_log2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clksw_ctrl #(.NUM_SER(2), .SLOW_LOG2(SLOW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] d, input logic pm, input logic swb, input logic st);
    @(negedge clk);
    wr_en = 1; wr_div = d; wr_pm_en = pm; wr_swb_en = swb; wr_stop = st;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_src(input int k, input logic v);
    case (k)
      0: ext_irq_edge = v;
      1: ser_rx_pin[0] = ~v;
      2: ser_rx_pin[1] = ~v;
      3: ser_tx_wr[0] = v;
      4: ser_tx_wr[1] = v;
      5: spi_ss_n = ~v;
      6: spi_tx_wr = v;
      7: rtc_tod_irq = v;
      default: dbg_entry = v;
    endcase
  endtask

  task automatic pulse_src(input int k);
    @(negedge clk); set_src(k, 1);
    @(negedge clk); set_src(k, 0);
  endtask

  task automatic enables(input logic v);
    ser_rx_en = {v, v}; ser_tx_en = {v, v}; spi_slave_mode = v; spi_tx_en = v;
  endtask

  function automatic int exp_log2(input int d, input int pm);
    if (pm && d == 0) return 8;
    if (pm && d == 3) return SLOW;
    return d;
  endfunction

  task automatic period(input int want, input string req);
    int n = 0;
    int guard = 0;
    while (!clk_en && guard < 4000) begin @(negedge clk); guard++; end
    @(negedge clk); n = 1;
    while (!clk_en && n < 4000) begin @(negedge clk); n++; end
    chk(n == want, req, n, want);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(div_code == 0 && !pm_en && !swb_en && !stop_req, "R11 regs", {div_code, pm_en, swb_en, stop_req}, 0);
    chk(eff_log2 == 0 && clk_en, "R11 strobe", {eff_log2, clk_en}, 1);

    // R1 R2 R3 R9 sweep over codes and enable
    for (int pm = 0; pm < 2; pm++)
      for (int d = 0; d < 4; d++) begin
        wr(2'(d), 1'(pm), 0, 0);
        chk(div_code == 2'(d) && pm_en == 1'(pm), "R3 load", {div_code, pm_en}, d * 2 + pm);
        chk(int'(eff_log2) == exp_log2(d, pm), pm ? "R2 ratio" : "R1 ratio", eff_log2, exp_log2(d, pm));
        chk(slow_src == (pm == 1 && d == 3), "R2 slow_src", slow_src, pm == 1 && d == 3);
        period(1 << exp_log2(d, pm), "R9 period");
      end

    // R8 stop does not move ratio
    wr(2'b00, 1, 0, 1);
    chk(stop_req && eff_log2 == 8, "R8 stop", {stop_req, eff_log2}, 24);
    wr(2'b00, 1, 0, 0);
    chk(!stop_req && eff_log2 == 8, "R8 stop clear", {stop_req, eff_log2}, 8);

    // R4 R5 every source from both low-power codes
    enables(1);
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 9; k++) begin
        logic [1:0] d;
        d = m ? 2'b11 : 2'b00;
        wr(d, 1, 1, 0);
        chk(pm_en && swb_en, "R3 arm", {pm_en, swb_en}, 3);
        pulse_src(k);
        chk(!pm_en, "R5 wake source clears pm", pm_en, 0);
        chk(div_code == d, "R4 div kept", div_code, d);
        chk(int'(eff_log2) == (m ? 3 : 0), "R4 result ratio", eff_log2, m ? 3 : 0);
      end

    // R5 gating: raw signals with enables off do nothing
    enables(0);
    for (int k = 1; k < 7; k++) begin
      wr(2'b00, 1, 1, 0);
      pulse_src(k);
      chk(pm_en && eff_log2 == 8, "R5 gated source ignored", pm_en, 1);
    end
    enables(1);

    // R10 swb off: wake ignored
    wr(2'b11, 1, 0, 0);
    pulse_src(7);
    chk(pm_en && eff_log2 == SLOW, "R10 swb off", pm_en, 1);
    // R10 pm off: swb armed but nothing to clear
    wr(2'b10, 0, 1, 0);
    pulse_src(0);
    chk(!pm_en && swb_en && eff_log2 == 2, "R10 pm off", {pm_en, swb_en}, 1);

    // R6 arm blocked while wake present in pm
    wr(2'b00, 1, 0, 0);
    @(negedge clk); rtc_tod_irq = 1;
    wr(2'b00, 1, 1, 0);
    chk(!swb_en && pm_en, "R6 arm blocked", {swb_en, pm_en}, 1);
    @(negedge clk); rtc_tod_irq = 0;
    wr(2'b00, 1, 1, 0);
    chk(swb_en && pm_en, "R6 arm after wake gone", {swb_en, pm_en}, 3);

    // R7 clear beats same-cycle write
    @(negedge clk);
    dbg_entry = 1; wr_en = 1; wr_div = 2'b00; wr_pm_en = 1; wr_swb_en = 1; wr_stop = 0;
    @(negedge clk);
    dbg_entry = 0; wr_en = 0;
    chk(!pm_en && eff_log2 == 0, "R7 clear wins", pm_en, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule